// File: doc/BRIEF.md
# Pixel Index Colour Remapper

This block sits between the pixel fetch path and the palette memory of a display controller. Each clock it takes one 8-bit pixel index and turns it into the palette address that the colour lookup will use. A 16-entry translation table, which software can load one entry at a time, and an 8-bit pixel mask shape the result. The exact path depends on the machine flavour being modelled and on whether the display runs in 16-colour or 256-colour mode.

For 16-colour operation, the low nibble of the pixel selects a table entry, and the mask is applied to that entry. For 256-colour operation there are two remap styles. The split style sends each nibble through the table on its own. The low-only style translates only the low nibble and takes the high nibble from the pixel or from a 4-bit colour-select input. A simpler machine flavour masks the raw pixel in 256-colour mode. A pass-through flavour forwards the pixel untouched.

The result is registered, so the palette address appears one clock after its pixel.

Top module: `palidx_remap`

## Requirements
- R1: While `rst_n` is low, `pal_addr` is 0 and table entry n holds the value n for every n in 0..15.
- R2: When `tbl_we` is high at a rising edge, entry `tbl_addr` takes all 8 bits of `tbl_wdata`. The change is first seen by the pixel sampled at the following edge.
- R3: With `machine_sel`=2'b00 and `wide_mode`=0, the output is the table entry at `pix_idx[3:0]` ANDed with `pix_mask`.
- R4: With `machine_sel`=2'b00, `wide_mode`=1 and `remap_sel`=0, the output is {entry[`pix_idx[7:4]`][3:0], entry[`pix_idx[3:0]`][3:0]} ANDed with `pix_mask`.
- R5: With `machine_sel`=2'b00, `wide_mode`=1, `remap_sel`=1 and `hi_from_csel`=1, the output is {`csel`, entry[`pix_idx[3:0]`][3:0]} ANDed with `pix_mask`.
- R6: With `machine_sel`=2'b00, `wide_mode`=1, `remap_sel`=1 and `hi_from_csel`=0, the output is {`pix_idx[7:4]`, entry[`pix_idx[3:0]`][3:0]} ANDed with `pix_mask`. In this case `csel` has no effect.
- R7: With `machine_sel`=2'b01 and `wide_mode`=1, the output is `pix_idx` ANDed with `pix_mask`. The table is not used.
- R8: With `machine_sel`=2'b01 and `wide_mode`=0, the output is the table entry at `pix_idx[3:0]` ANDed with `pix_mask`.
- R9: With `machine_sel[1]`=1, the output is `pix_idx` unchanged, whatever the mask and table hold.
- R10: `pal_addr` is updated at each rising edge from the inputs sampled at that edge. A table write or mask change made at a given edge does not alter the address produced at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_idx | input | 8 | Incoming pixel index |
| machine_sel | input | 2 | 00 full table machine, 01 simple machine, 1x pass-through |
| wide_mode | input | 1 | 1 selects 256-colour mode, 0 selects 16-colour mode |
| remap_sel | input | 1 | 256-colour remap style: 0 split nibbles, 1 low nibble only |
| hi_from_csel | input | 1 | Low-only style: take the high nibble from `csel` |
| csel | input | 4 | Colour-select high nibble |
| pix_mask | input | 8 | Pixel mask ANDed into the address |
| tbl_we | input | 1 | Translation table write enable |
| tbl_addr | input | 4 | Translation table entry to write |
| tbl_wdata | input | 8 | Translation table write data |
| pal_addr | output | 8 | Registered palette address |

## Verification
The hardest case to reach is the same-edge collision. Here a table write and a pixel that reads the same entry arrive at one clock edge. The old entry must leave and the new entry must appear only on the next pixel. The bench creates this by presenting the write and the colliding pixel in the same cycle, then repeating the pixel. The split-nibble style is exercised with table contents whose high bits differ from their low bits, which shows that only the low four bits of each entry are used.

// File: rtl/palidx_remap.sv
module palidx_remap #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_idx,
  input  logic [1:0]       machine_sel,
  input  logic             wide_mode,
  input  logic             remap_sel,
  input  logic             hi_from_csel,
  input  logic [3:0]       csel,
  input  logic [PIX_W-1:0] pix_mask,
  input  logic             tbl_we,
  input  logic [3:0]       tbl_addr,
  input  logic [PIX_W-1:0] tbl_wdata,
  output logic [PIX_W-1:0] pal_addr
);
  localparam int ENTRIES = 16;

  logic [PIX_W-1:0] xlat [ENTRIES];
  logic [PIX_W-1:0] lo_ent, hi_ent, nxt;
  logic [3:0]       upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) xlat[i] <= PIX_W'(i);
    end else if (tbl_we) begin
      xlat[tbl_addr] <= tbl_wdata;
    end
  end

  assign lo_ent = xlat[pix_idx[3:0]];
  assign hi_ent = xlat[pix_idx[7:4]];
  assign upper  = remap_sel ? (hi_from_csel ? csel : pix_idx[7:4]) : hi_ent[3:0];

  always_comb begin
    if (machine_sel[1])
      nxt = pix_idx;
    else if (!wide_mode)
      nxt = lo_ent & pix_mask;
    else if (machine_sel[0])
      nxt = pix_idx & pix_mask;
    else
      nxt = {upper, lo_ent[3:0]} & pix_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pal_addr <= '0;
    else        pal_addr <= nxt;
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (pal_addr == '0); // R1
  end

  AST_PASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(machine_sel[1]) |-> pal_addr == $past(pix_idx)); // R9

  AST_MASK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(machine_sel[1]) |-> (pal_addr & ~$past(pix_mask)) == '0); // R3

  AST_SIMPLE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(machine_sel) == 2'b01 && $past(wide_mode)
    |-> pal_addr == ($past(pix_idx) & $past(pix_mask))); // R7

  AST_CSEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(machine_sel) == 2'b00 && $past(wide_mode) && $past(remap_sel) && $past(hi_from_csel)
    |-> pal_addr[7:4] == ($past(csel) & $past(pix_mask[7:4]))); // R5

  AST_PIX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(machine_sel) == 2'b00 && $past(wide_mode) && $past(remap_sel) && !$past(hi_from_csel)
    |-> pal_addr[7:4] == ($past(pix_idx[7:4]) & $past(pix_mask[7:4]))); // R6
endmodule

// File: tb/palidx_remap_bench.sv
module palidx_remap_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix_idx = '0;
  logic [1:0] machine_sel = '0;
  logic       wide_mode = 1'b0, remap_sel = 1'b0, hi_from_csel = 1'b0;
  logic [3:0] csel = '0;
  logic [7:0] pix_mask = 8'hFF;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] pal_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  palidx_remap u_palidx_remap (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .machine_sel(machine_sel),
    .wide_mode(wide_mode), .remap_sel(remap_sel), .hi_from_csel(hi_from_csel),
    .csel(csel), .pix_mask(pix_mask), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .pal_addr(pal_addr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m, input logic w, input logic r, input logic h, input logic [3:0] c);
    @(negedge clk);
    machine_sel = m; wide_mode = w; remap_sel = r; hi_from_csel = h; csel = c;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(posedge clk);
    #1 tbl_we = 1'b0;
    model[a] = d;
  endtask

  task automatic pix(input string req, input logic [7:0] p, input logic [7:0] m, input logic [7:0] exp);
    @(negedge clk);
    pix_idx = p; pix_mask = m;
    @(posedge clk);
    #1 check(req, pal_addr, exp);
  endtask

  task automatic t_reset;
    check("R1 reset output", pal_addr, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0, 4'h0);
    for (int n = 0; n < 16; n++) pix("R1 default entry", 8'(n), 8'hFF, 8'(n));
  endtask

  task automatic t_narrow;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0, 4'h0);
    wr(4'h5, 8'hC7);
    pix("R2 written entry", 8'h35, 8'hFF, 8'hC7);
    pix("R3 masked entry", 8'h35, 8'hF0, 8'hC0);
    pix("R3 high nibble ignored", 8'hE5, 8'h3F, 8'h07);
  endtask

  task automatic t_split;
    wr(4'h2, 8'h1E);
    wr(4'hA, 8'h29);
    set_mode(2'b00, 1'b1, 1'b0, 1'b0, 4'h0);
    pix("R4 split nibbles", 8'hA2, 8'hFF, 8'h9E);
    pix("R4 split masked", 8'hA2, 8'h3C, 8'h1C);
    pix("R4 swapped nibbles", 8'h2A, 8'hFF, 8'hE9);
  endtask

  task automatic t_lowonly;
    set_mode(2'b00, 1'b1, 1'b1, 1'b1, 4'h6);
    pix("R5 csel high", 8'hA2, 8'hFF, 8'h6E);
    pix("R5 csel masked", 8'hA2, 8'h5F, 8'h4E);
    set_mode(2'b00, 1'b1, 1'b1, 1'b0, 4'h6);
    pix("R6 pixel high", 8'hA2, 8'hFF, 8'hAE);
    set_mode(2'b00, 1'b1, 1'b1, 1'b0, 4'h3);
    pix("R6 csel no effect", 8'hA2, 8'hFF, 8'hAE);
  endtask

  task automatic t_simple;
    set_mode(2'b01, 1'b1, 1'b0, 1'b0, 4'h0);
    pix("R7 raw masked", 8'hA2, 8'h0F, 8'h02);
    pix("R7 no table", 8'h55, 8'hFF, 8'h55);
    set_mode(2'b01, 1'b0, 1'b0, 1'b0, 4'h0);
    pix("R8 table used", 8'hA2, 8'hFF, 8'h1E);
    pix("R8 table masked", 8'hA2, 8'hF0, 8'h10);
  endtask

  task automatic t_pass;
    set_mode(2'b10, 1'b1, 1'b0, 1'b0, 4'h0);
    pix("R9 raw through", 8'hA2, 8'h00, 8'hA2);
    set_mode(2'b11, 1'b0, 1'b1, 1'b1, 4'h0);
    pix("R9 raw narrow", 8'h35, 8'h0F, 8'h35);
  endtask

  task automatic t_collide;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0, 4'h0);
    @(negedge clk);
    pix_idx = 8'h03; pix_mask = 8'hFF;
    tbl_we = 1'b1; tbl_addr = 4'h3; tbl_wdata = 8'hAB;
    @(posedge clk);
    #1 tbl_we = 1'b0;
    check("R10 same-edge write unseen", pal_addr, 8'h03);
    pix("R10 write seen next", 8'h03, 8'hFF, 8'hAB);
    @(negedge clk) pix_idx = 8'h03;
    @(posedge clk);
    #1 check("R10 latency one", pal_addr, 8'hAB);
    @(negedge clk) pix_mask = 8'h0F;
    #1 check("R10 output held between edges", pal_addr, 8'hAB);
    @(posedge clk);
    #1 check("R10 mask at edge", pal_addr, 8'h0B);
  endtask

  initial begin
    for (int n = 0; n < 16; n++) model[n] = 8'(n);
    #7;
    t_reset;
    t_narrow;
    t_split;
    t_lowonly;
    t_simple;
    t_pass;
    t_collide;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule